// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Controller

This block owns one bank of a DRAM device. It remembers whether the bank's single row buffer holds an open row and which one it is. It accepts one column access at a time, made of a row address, a column address and a read/write flag. It classifies the access against the open row and then issues the bank commands that serve it, one per cycle. Every command waits a configurable number of cycles after the one before it, so the three kinds of access take different times to complete.

A row hit needs only the column command. An access to an empty bank first activates the row. A conflict first closes the open row, then activates the new one, and then issues the column command. A page-policy input is sampled with each request. With open-page the row stays in the buffer for later accesses. With close-page the bank is precharged straight after the data phase and is left empty. The row address and the column address share one address output, each presented with its own command.

Top module: `rowbuf_bank_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `row_open` is 0 and `cmd` is NOP (0).
- R2: A request whose row equals the open row (hit) produces only a column command in the first cycle after acceptance, and `resp_valid` pulses T_CL cycles after that column command.
- R3: A request to a bank with no open row produces ACT (1) with the row on `cmd_addr` in the first cycle after acceptance, then the column command T_RCD cycles later.
- R4: A request to a different row than the open one produces PRE (4) in the first cycle after acceptance, ACT of the new row T_RP cycles later, then the column command T_RCD cycles after the ACT; an ACT never comes sooner than T_RP cycles after a PRE.
- R5: Command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4. The column command is WR when `req_write` was 1 and RD otherwise, and it carries the column address on `cmd_addr`.
- R6: Under open-page (`close_page`=0), `ready` returns in the same cycle as `resp_valid`, and the accessed row stays open with `open_row` equal to it.
- R7: Under close-page (`close_page`=1), PRE is issued in the `resp_valid` cycle, `ready` returns T_RP cycles later, and `row_open` is 0 from that PRE onward.
- R8: `ready` is 1 only while the bank is idle, no command is issued while `ready` is 1, and a request presented while `ready` is 0 is ignored and changes neither the command stream nor the open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `ready` is 1 |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_row | input | ADDR_W | Row address of the request |
| req_col | input | ADDR_W | Column address of the request |
| close_page | input | 1 | Page policy for this request: 1 = close, 0 = open |
| ready | output | 1 | Bank idle and able to take a request |
| cmd | output | 3 | Bank command this cycle (NOP, ACT, RD, WR, PRE) |
| cmd_addr | output | ADDR_W | Row address with ACT, column address with RD/WR |
| resp_valid | output | 1 | One-cycle pulse at the end of the data phase |
| row_open | output | 1 | Row buffer holds an open row |
| open_row | output | ADDR_W | Row held in the row buffer |

## Verification
Under close-page, the end of the data phase and the closing precharge fall in the same cycle: `resp_valid` pulses while `cmd` shows PRE. The bench provokes this with close-page hits and close-page accesses to an empty bank. Its scoreboard queues the response before the precharge with the same expected cycle, and the monitor pops both items in that cycle. Each item is judged on its exact cycle number, so a response or precharge that slips by one cycle is caught. The same pass also checks that `ready` stays low up to the last precharge gap.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } bank_cmd_e;

    typedef enum logic [1:0] {
        ACC_HIT,
        ACC_EMPTY,
        ACC_CONFLICT
    } access_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_RP,
        ST_WAIT_RCD,
        ST_WAIT_CL,
        ST_WAIT_CLOSE
    } bank_state_e;

    typedef enum logic [1:0] {
        GAP_RP,
        GAP_RCD,
        GAP_CL
    } gap_sel_e;

endpackage

// File: rtl/rb_classify.sv
module rb_classify
    import rowbuf_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              buf_open,
    input  logic [ADDR_W-1:0] buf_row,
    input  logic [ADDR_W-1:0] want_row,
    output access_kind_e      kind
);

    always_comb begin
        if (!buf_open) begin
            kind = ACC_EMPTY;
        end else if (buf_row == want_row) begin
            kind = ACC_HIT;
        end else begin
            kind = ACC_CONFLICT;
        end
    end

endmodule

// File: rtl/rb_gap_timer.sv
module rb_gap_timer
    import rowbuf_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int T_RCD = 3,
    parameter int T_CL  = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  gap_sel_e sel,
    output logic     expired
);

    localparam int T_MAX = (T_RP > T_RCD) ? ((T_RP > T_CL) ? T_RP : T_CL)
                                          : ((T_RCD > T_CL) ? T_RCD : T_CL);
    localparam int CNT_W = $clog2(T_MAX + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        case (sel)
            GAP_RP:  load_val = CNT_W'(T_RP - 1);
            GAP_RCD: load_val = CNT_W'(T_RCD - 1);
            default: load_val = CNT_W'(T_CL - 1);
        endcase
    end

    always_comb begin
        if (start) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/rowbuf_bank_ctrl.sv
module rowbuf_bank_ctrl
    import rowbuf_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int T_RP   = 3,
    parameter int T_RCD  = 3,
    parameter int T_CL   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_row,
    input  logic [ADDR_W-1:0] req_col,
    input  logic              close_page,
    output logic              ready,
    output logic [2:0]        cmd,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              resp_valid,
    output logic              row_open,
    output logic [ADDR_W-1:0] open_row
);

    localparam int CHK_W = $clog2(T_RP + T_RCD + 2) + 1;

    typedef struct packed {
        bank_state_e       state;
        bank_cmd_e         cmd;
        logic [ADDR_W-1:0] addr;
        logic              open;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] pend_row;
        logic [ADDR_W-1:0] pend_col;
        logic              pend_wr;
        logic              close;
        logic              resp;
    } bank_regs_t;

    bank_regs_t   d, q;
    access_kind_e kind;
    logic         t_start;
    gap_sel_e     t_sel;
    logic         t_expired;

    rb_classify #(.ADDR_W(ADDR_W)) u_classify (
        .buf_open (q.open),
        .buf_row  (q.row),
        .want_row (req_row),
        .kind     (kind)
    );

    rb_gap_timer #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (t_start),
        .sel     (t_sel),
        .expired (t_expired)
    );

    always_comb begin
        d       = q;
        d.cmd   = CMD_NOP;
        d.resp  = 1'b0;
        t_start = 1'b0;
        t_sel   = GAP_RP;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.pend_row = req_row;
                    d.pend_col = req_col;
                    d.pend_wr  = req_write;
                    d.close    = close_page;
                    t_start    = 1'b1;
                    case (kind)
                        ACC_HIT: begin
                            d.cmd   = req_write ? CMD_WR : CMD_RD;
                            d.addr  = req_col;
                            d.state = ST_WAIT_CL;
                            t_sel   = GAP_CL;
                        end
                        ACC_EMPTY: begin
                            d.cmd   = CMD_ACT;
                            d.addr  = req_row;
                            d.open  = 1'b1;
                            d.row   = req_row;
                            d.state = ST_WAIT_RCD;
                            t_sel   = GAP_RCD;
                        end
                        default: begin
                            d.cmd   = CMD_PRE;
                            d.addr  = '0;
                            d.open  = 1'b0;
                            d.state = ST_WAIT_RP;
                            t_sel   = GAP_RP;
                        end
                    endcase
                end
            end
            ST_WAIT_RP: begin
                if (t_expired) begin
                    d.cmd   = CMD_ACT;
                    d.addr  = q.pend_row;
                    d.open  = 1'b1;
                    d.row   = q.pend_row;
                    d.state = ST_WAIT_RCD;
                    t_start = 1'b1;
                    t_sel   = GAP_RCD;
                end
            end
            ST_WAIT_RCD: begin
                if (t_expired) begin
                    d.cmd   = q.pend_wr ? CMD_WR : CMD_RD;
                    d.addr  = q.pend_col;
                    d.state = ST_WAIT_CL;
                    t_start = 1'b1;
                    t_sel   = GAP_CL;
                end
            end
            ST_WAIT_CL: begin
                if (t_expired) begin
                    d.resp = 1'b1;
                    if (q.close) begin
                        d.cmd   = CMD_PRE;
                        d.addr  = '0;
                        d.open  = 1'b0;
                        d.state = ST_WAIT_CLOSE;
                        t_start = 1'b1;
                        t_sel   = GAP_RP;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end
            end
            ST_WAIT_CLOSE: begin
                if (t_expired) begin
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cmd: CMD_NOP, default: '0};
        end else begin
            q <= d;
        end
    end

    assign ready      = (q.state == ST_IDLE);
    assign cmd        = q.cmd;
    assign cmd_addr   = q.addr;
    assign resp_valid = q.resp;
    assign row_open   = q.open;
    assign open_row   = q.row;

    // Cycles since the last PRE and the last ACT, saturating, for gap checks.
    logic [CHK_W-1:0] since_pre_q, since_act_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre_q <= CHK_W'(T_RP);
            since_act_q <= CHK_W'(T_RCD);
        end else begin
            if (cmd == CMD_PRE)                 since_pre_q <= CHK_W'(1);
            else if (since_pre_q < CHK_W'(T_RP)) since_pre_q <= since_pre_q + 1'b1;
            if (cmd == CMD_ACT)                  since_act_q <= CHK_W'(1);
            else if (since_act_q < CHK_W'(T_RCD)) since_act_q <= since_act_q + 1'b1;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        $past(!rst_n) |-> (ready && !row_open && cmd == CMD_NOP));

    a_r4_rp_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> (since_pre_q >= CHK_W'(T_RP)));

    a_r3_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> (since_act_q >= CHK_W'(T_RCD)));

    a_r5_col_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> row_open);

    a_r7_pre_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> !row_open);

    a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cmd == CMD_NOP));

    a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> !ready);

    a_r8_busy_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && cmd != CMD_ACT && $past(cmd) != CMD_ACT && row_open) |-> $stable(open_row));

endmodule

// File: tb/rowbuf_bank_ctrl_tb.sv
module rowbuf_bank_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 12;
    localparam int T_RP  = 3;
    localparam int T_RCD = 3;
    localparam int T_CL  = 2;
    localparam int K_RESP = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_row = '0;
    logic [AW-1:0] req_col = '0;
    logic          close_page = 1'b0;
    logic          ready;
    logic [2:0]    cmd;
    logic [AW-1:0] cmd_addr;
    logic          resp_valid;
    logic          row_open;
    logic [AW-1:0] open_row;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int            kind;
        logic [AW-1:0] addr;
        int            at;
        string         tag;
    } exp_t;
    exp_t sbq[$];

    bit            m_open = 1'b0;
    logic [AW-1:0] m_row = '0;

    rowbuf_bank_ctrl #(.ADDR_W(AW), .T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_row    (req_row),
        .req_col    (req_col),
        .close_page (close_page),
        .ready      (ready),
        .cmd        (cmd),
        .cmd_addr   (cmd_addr),
        .resp_valid (resp_valid),
        .row_open   (row_open),
        .open_row   (open_row)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int kind, input logic [AW-1:0] addr, input int at, input string tag);
        exp_t e;
        e.kind = kind; e.addr = addr; e.at = at; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic pop_cmp(input int kind, input logic [AW-1:0] addr);
        exp_t e;
        if (sbq.size() == 0) begin
            check(1'b0, "R8 unexpected output", kind, 0);
        end else begin
            e = sbq.pop_front();
            check(kind == e.kind, {e.tag, " kind"}, kind, e.kind);
            check(cyc == e.at, {e.tag, " cycle"}, cyc, e.at);
            if (kind == 1 || kind == 2 || kind == 3)
                check(addr == e.addr, {e.tag, " addr"}, int'(addr), int'(e.addr));
        end
    endtask

    // Monitor: response is compared before a command of the same cycle.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (resp_valid) pop_cmp(K_RESP, '0);
            if (cmd != 3'd0) pop_cmp(int'(cmd), cmd_addr);
        end
    end

    task automatic do_req(input bit wr, input logic [AW-1:0] row, input logic [AW-1:0] col,
                          input bit cls);
        int a, colt, respt, idle;
        @(negedge clk);
        while (!ready) @(negedge clk);
        a = cyc + 1;
        if (m_open && m_row == row) begin
            colt = a;                                       // R2 hit
        end else if (!m_open) begin
            push(1, row, a, "R3 ACT");
            colt = a + T_RCD;
        end else begin
            push(4, '0, a, "R4 PRE");
            push(1, row, a + T_RP, "R4 ACT");
            colt = a + T_RP + T_RCD;
        end
        push(wr ? 3 : 2, col, colt, "R5 column");
        respt = colt + T_CL;
        push(K_RESP, '0, respt, "R2 resp");
        if (cls) begin
            push(4, '0, respt, "R7 close PRE");
            idle = respt + T_RP;
        end else begin
            idle = respt;
        end
        req_valid = 1'b1; req_write = wr; req_row = row; req_col = col; close_page = cls;
        @(negedge clk);
        // R8: a conflicting request while busy must be ignored
        req_row = ~row; req_col = ~col; req_write = ~wr; close_page = ~cls;
        @(negedge clk);
        req_valid = 1'b0;
        while (cyc < idle - 1) @(negedge clk);
        check(ready == 1'b0, "R8 busy before idle", int'(ready), 0);
        @(negedge clk);
        check(ready == 1'b1, cls ? "R7 ready after close" : "R6 ready at resp", int'(ready), 1);
        check(row_open == !cls, cls ? "R7 row closed" : "R6 row kept", int'(row_open), int'(!cls));
        if (!cls) check(open_row == row, "R6 open row", int'(open_row), int'(row));
        m_open = !cls;
        m_row  = row;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        nfail++;
        nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R1 ready", int'(ready), 1);
        check(row_open == 1'b0, "R1 row_open", int'(row_open), 0);
        check(cmd == 3'd0, "R1 cmd NOP", int'(cmd), 0);

        do_req(1'b0, 12'h005, 12'h010, 1'b0);   // R3 empty, open page
        do_req(1'b0, 12'h005, 12'h009, 1'b0);   // R2 hit read
        do_req(1'b1, 12'h005, 12'h3A0, 1'b0);   // R2 hit write, R5
        do_req(1'b0, 12'h007, 12'h001, 1'b0);   // R4 conflict
        do_req(1'b1, 12'h007, 12'h002, 1'b1);   // R7 hit then close
        do_req(1'b0, 12'h003, 12'hFFF, 1'b1);   // R3 empty, R7 close
        do_req(1'b1, 12'hFFF, 12'h000, 1'b0);   // R3 empty, boundary row
        do_req(1'b0, 12'h000, 12'h7FF, 1'b0);   // R4 conflict, row 0
        do_req(1'b1, 12'h000, 12'h800, 1'b1);   // R2 hit with close, R7

        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R8 scoreboard drained", sbq.size(), 0);
        check(cmd == 3'd0, "R8 idle NOP", int'(cmd), 0);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule